// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This controller runs a scan chain that has been cut into `NUM_SEG` segments of equal length, and it lets only one segment shift at a time. A start pulse, taken while scan-enable is high, begins a shift pass. The controller raises one clock-enable per segment in place of a gated clock. Segment 0 is active first, then segment 1, and so on, and each segment shifts for the programmed number of cycles. The idle segments keep their clock-enables low and hold their contents.

The steering logic acts as the bypass multiplexers. It routes the serial scan input into the active segment only and selects the active segment's output as the scan output. A pass therefore takes the same number of cycles as one unsegmented chain of `NUM_SEG * seg_len` flops. `NUM_CH` parallel chains share the controller, and segment k of every chain uses the same enable. The scan data is a fixed-rate serial stream with no valid/ready handshake. While `busy` is high the source must present one new bit per chain on every cycle, and the sink must take one bit per chain on every cycle. No back-pressure exists, because a stalled cycle would change the shift count.

When scan-enable goes low the block treats it as a capture. All segment enables rise together for that first low cycle only, and any pass in progress is dropped.

Top module: `seg_scan_ctrl`

## Requirements
- R1: After reset, `seg_clk_en`, `seg_din`, `scan_out`, `busy` and `done` are all zero.
- R2: A start is accepted only when `start` is high, `scan_en` is high, `busy` is low and `seg_len` is non-zero. `busy` is high from the following cycle on. A start with `scan_en` low has no effect on `busy`.
- R3: While `busy` and `scan_en` are high, exactly one bit of `seg_clk_en` is set. Bit k is set (enable vector equal to 1<<k) for shift cycles k*L through k*L+L-1, where L is the length latched at start.
- R4: A pass lasts exactly `NUM_SEG*L` cycles with `busy` high. `done` is high for exactly one cycle, namely the first cycle in which `busy` is low again.
- R5: While shifting, `seg_din[k*NUM_CH+c]` equals `scan_in[c]` for the active segment k and is 0 for every idle segment. `scan_out[c]` equals `seg_dout[k*NUM_CH+c]` of the active segment, and is 0 when `busy` is low.
- R6: All `NUM_CH` chains are steered with the same segment index. After a full pass, segment k of chain c holds the L bits that were presented on `scan_in[c]` during segment k's window, with the first of them in the most significant position. During that window it has emitted its old contents, most significant bit first.
- R7: In the first cycle of `scan_en` low, all bits of `seg_clk_en` are set. In later low cycles they are all clear. Low `scan_en` clears `busy` and the counters without raising `done`.
- R8: A start pulse while `busy` is high is ignored: the pass keeps its position and its length.
- R9: A start with `seg_len` equal to 0 is ignored, and `busy` stays low.
- R10: `seg_len` is latched at start. Changing it during a pass does not alter the segment lengths or the total pass length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | 1 = shift mode, 0 = capture mode |
| start | input | 1 | Pulse that starts a shift pass |
| seg_len | input | LEN_W | Flops per segment, latched at start |
| scan_in | input | NUM_CH | Serial scan input, one bit per chain |
| seg_dout | input | NUM_SEG*NUM_CH | Serial output of each segment, index k*NUM_CH+c |
| seg_din | output | NUM_SEG*NUM_CH | Serial input steered to each segment, index k*NUM_CH+c |
| seg_clk_en | output | NUM_SEG | Clock-enable per segment |
| scan_out | output | NUM_CH | Serial scan output, one bit per chain |
| busy | output | 1 | Shift pass in progress |
| done | output | 1 | One-cycle pulse after the last shift |

## Verification
The hardest state to reach from the ports is a pass disturbed in mid-flight. The disturbances are a second start pulse, a changed length, and a capture that lands partway through a segment. The stimulus reaches that state by counting cycles from the accepted start. It injects the extra start and the new length while segment 1 is active, and it checks that the segment boundaries and the end of the pass fall on the cycles predicted from the length latched at start. A separate pass drops `scan_en` while segment 1 is shifting, to show the capture pulse and the silent abort.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/seg_bit_cnt.sv
module seg_bit_cnt #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             go,
  input  logic             adv,
  input  logic [LEN_W-1:0] seg_len,
  output logic             wrap
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  assign wrap = adv && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (!scan_en) begin
      cnt_q <= '0;
    end else if (go) begin
      cnt_q <= '0;
      len_q <= seg_len;
    end else if (adv) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (cnt_q < len_q));

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !go) |=> $stable(len_q));

  // R8
  start_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/seg_idx_cnt.sv
module seg_idx_cnt #(
  parameter int NUM_SEG = 4,
  parameter int IW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  input  logic          go,
  input  logic          wrap,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(NUM_SEG - 1);
  logic last;

  assign last = wrap && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (!scan_en) begin
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (go) begin
      idx  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (last) begin
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b1;
    end else begin
      done <= 1'b0;
      if (wrap) idx <= idx + 1'b1;
    end
  end

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wrap && !last) |=> (idx == $past(idx) + 1'b1));

  // R4
  done_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (!busy && !done));
endmodule

// File: rtl/seg_steer.sv
module seg_steer #(
  parameter int NUM_SEG = 4,
  parameter int NUM_CH  = 2,
  parameter int IW      = 2
) (
  input  logic [IW-1:0]             idx,
  input  logic                      shifting,
  input  logic                      busy,
  input  logic [NUM_CH-1:0]         scan_in,
  input  logic [NUM_SEG*NUM_CH-1:0] seg_dout,
  output logic [NUM_SEG-1:0]        act,
  output logic [NUM_SEG*NUM_CH-1:0] seg_din,
  output logic [NUM_CH-1:0]         scan_out
);
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    assign act[k] = shifting && (idx == IW'(k));
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign seg_din[k*NUM_CH+c] = act[k] ? scan_in[c] : 1'b0;
    end
  end

  always_comb begin
    scan_out = '0;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (busy && idx == IW'(k)) scan_out = seg_dout[k*NUM_CH +: NUM_CH];
    end
  end
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl #(
  parameter int NUM_SEG = 4,
  parameter int NUM_CH  = 2,
  parameter int LEN_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_en,
  input  logic                      start,
  input  logic [LEN_W-1:0]          seg_len,
  input  logic [NUM_CH-1:0]         scan_in,
  input  logic [NUM_SEG*NUM_CH-1:0] seg_dout,
  output logic [NUM_SEG*NUM_CH-1:0] seg_din,
  output logic [NUM_SEG-1:0]        seg_clk_en,
  output logic [NUM_CH-1:0]         scan_out,
  output logic                      busy,
  output logic                      done
);
  localparam int IW = seg_scan_pkg::idx_width(NUM_SEG);

  logic          go, adv, wrap, se_q, cap;
  logic [IW-1:0] idx;
  logic [NUM_SEG-1:0] act;

  assign go  = start && scan_en && !busy && (seg_len != '0);
  assign adv = busy && scan_en;
  assign cap = !scan_en && se_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) se_q <= 1'b0;
    else        se_q <= scan_en;
  end

  seg_bit_cnt #(.LEN_W(LEN_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .go(go), .adv(adv),
    .seg_len(seg_len), .wrap(wrap)
  );

  seg_idx_cnt #(.NUM_SEG(NUM_SEG), .IW(IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .go(go), .wrap(wrap),
    .idx(idx), .busy(busy), .done(done)
  );

  seg_steer #(.NUM_SEG(NUM_SEG), .NUM_CH(NUM_CH), .IW(IW)) u_steer (
    .idx(idx), .shifting(adv), .busy(busy), .scan_in(scan_in),
    .seg_dout(seg_dout), .act(act), .seg_din(seg_din), .scan_out(scan_out)
  );

  assign seg_clk_en = cap ? '1 : act;

  // R3
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ($countones(seg_clk_en) == 1));

  // R7
  capture_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && se_q) |-> (&seg_clk_en));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && scan_en && !busy && seg_len == '0) |=> !busy);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scan_out == '0 && seg_din == '0));
endmodule

// File: tb/seg_scan_ctrl_tb.sv
module seg_scan_ctrl_tb;
  localparam int NS = 4;
  localparam int NC = 2;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b1;
  logic start = 1'b0;
  logic [LW-1:0] seg_len = '0;
  logic [NC-1:0] scan_in = '0;
  logic [NS*NC-1:0] seg_dout, seg_din;
  logic [NS-1:0] seg_clk_en;
  logic [NC-1:0] scan_out;
  logic busy, done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int cur_len = 1;
  logic [15:0] mdl [NS][NC];
  logic [15:0] init_v [NS][NC];
  logic [15:0] exp_v [NS][NC];

  always #2 clk = ~clk;

  seg_scan_ctrl #(.NUM_SEG(NS), .NUM_CH(NC), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .start(start),
    .seg_len(seg_len), .scan_in(scan_in), .seg_dout(seg_dout),
    .seg_din(seg_din), .seg_clk_en(seg_clk_en), .scan_out(scan_out),
    .busy(busy), .done(done)
  );

  // Segment models: shift registers with enables
  always @(posedge clk) begin
    for (int k = 0; k < NS; k++)
      for (int c = 0; c < NC; c++)
        if (seg_clk_en[k]) mdl[k][c] <= {mdl[k][c][14:0], seg_din[k*NC+c]};
  end

  always_comb begin
    for (int k = 0; k < NS; k++)
      for (int c = 0; c < NC; c++)
        seg_dout[k*NC+c] = mdl[k][c][cur_len-1];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic in_bit(int seed, int k, int c, int j);
    int v;
    v = seed * 7 + k * 5 + c * 3 + j * 11;
    return logic'(v[0] ^ v[2] ^ v[3]);
  endfunction

  // R1
  task automatic t_reset();
    chk("R1 en", 32'(seg_clk_en), 0);
    chk("R1 din", 32'(seg_din), 0);
    chk("R1 out", 32'(scan_out), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
  endtask

  // R2 R3 R4 R5 R6 R8 R10: full pass, optional disturbance in segment 1
  task automatic t_pass(input int len, input int seed, input bit disturb);
    int n;
    logic [NS-1:0] exp_en;
    cur_len = len;
    for (int k = 0; k < NS; k++)
      for (int c = 0; c < NC; c++) begin
        init_v[k][c] = 16'hB4E1 ^ 16'(k * 613 + c * 97 + seed * 29);
        mdl[k][c] = init_v[k][c];
        exp_v[k][c] = init_v[k][c];
      end
    seg_len = LW'(len);
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R2 busy rise", 32'(busy), 1);
    n = NS * len;
    for (int i = 0; i < n; i++) begin
      int k, j;
      k = i / len;
      j = i % len;
      exp_en = NS'(1) << k;
      for (int c = 0; c < NC; c++) scan_in[c] = in_bit(seed, k, c, j);
      if (disturb && i == len + 1) begin
        start = 1'b1;
        seg_len = LW'(len + 3);
      end else begin
        start = 1'b0;
      end
      #1;
      chk(disturb ? "R8 R10 busy" : "R4 busy", 32'(busy), 1);
      chk("R3 enable", 32'(seg_clk_en), 32'(exp_en));
      for (int c = 0; c < NC; c++) begin
        chk("R6 scan_out", 32'(scan_out[c]), 32'(init_v[k][c][len-1-j]));
        exp_v[k][c] = {exp_v[k][c][14:0], scan_in[c]};
      end
      for (int kk = 0; kk < NS; kk++)
        for (int c = 0; c < NC; c++)
          chk("R5 din", 32'(seg_din[kk*NC+c]), (kk == k) ? 32'(scan_in[c]) : 0);
      step();
    end
    start = 1'b0;
    seg_len = LW'(len);
    chk("R4 busy end", 32'(busy), 0);
    chk("R4 done", 32'(done), 1);
    chk("R5 out idle", 32'(scan_out), 0);
    for (int k = 0; k < NS; k++)
      for (int c = 0; c < NC; c++)
        chk("R6 content", 32'(mdl[k][c]), 32'(exp_v[k][c]));
    step();
    chk("R4 done pulse", 32'(done), 0);
  endtask

  // R7: capture from idle
  task automatic t_capture();
    scan_en = 1'b0;
    #1;
    chk("R7 all en", 32'(seg_clk_en), 32'({NS{1'b1}}));
    step();
    chk("R7 one cycle", 32'(seg_clk_en), 0);
    start = 1'b1;
    seg_len = LW'(3);
    step();
    start = 1'b0;
    chk("R2 start scan_en low", 32'(busy), 0);
    scan_en = 1'b1;
    step();
    chk("R7 back", 32'(seg_clk_en), 0);
  endtask

  // R7: capture aborts a pass
  task automatic t_abort();
    cur_len = 4;
    seg_len = LW'(4);
    start = 1'b1;
    step();
    start = 1'b0;
    for (int i = 0; i < 5; i++) step();
    chk("R3 mid seg1", 32'(seg_clk_en), 32'(2));
    scan_en = 1'b0;
    #1;
    chk("R7 abort en", 32'(seg_clk_en), 32'({NS{1'b1}}));
    step();
    chk("R7 abort busy", 32'(busy), 0);
    chk("R7 no done", 32'(done), 0);
    scan_en = 1'b1;
    step();
    chk("R7 idle after", 32'(seg_clk_en), 0);
    chk("R7 done stays", 32'(done), 0);
  endtask

  // R9
  task automatic t_zero();
    seg_len = '0;
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R9 busy", 32'(busy), 0);
    chk("R9 en", 32'(seg_clk_en), 0);
  endtask

  initial begin
    for (int k = 0; k < NS; k++)
      for (int c = 0; c < NC; c++) mdl[k][c] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_pass(3, 1, 1'b0);
    t_pass(1, 2, 1'b0);
    t_pass(5, 3, 1'b1);
    t_pass(15, 4, 1'b0);
    t_capture();
    t_abort();
    t_zero();
    t_pass(2, 5, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule